// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Controller

This block handles interrupt delivery for one processor in a multiprocessor interrupt controller. It tracks up to `NSRC` sources in two bit-vectors. The *raised* set holds sources that were delivered but not yet taken. The *in-service* set holds sources the processor has taken but not yet retired. An *activity* bit per source follows each delivery until it is acknowledged or withdrawn.

A routing stage elsewhere sends a deliver request (a source index) together with each source's priority, vector and sense. The block filters the request against a 4-bit task-priority threshold and drives a single interrupt line. The processor answers that line by reading the acknowledge address, which returns an 8-bit vector: either the source's own vector or a spurious vector. The processor later writes the end-of-interrupt address to retire the most urgent in-service source.

Register addresses on `reg_addr` are: 0 = task priority, 1 = acknowledge, 2 = end-of-interrupt, 3 = unused. Read data on `reg_rdata` is combinational and valid in the cycle `reg_rd` is high. All state changes take effect at the next rising clock edge.

Top module: `irq_ack_ctl`

## Requirements
- R1: After reset, `irq_out` is 0, a task-priority read returns 0x0F, and an acknowledge read with an empty raised set returns `spur_vec`.
- R2: A write to address 0 keeps only `reg_wdata[3:0]`, and a read of address 0 returns that value zero-extended to 8 bits.
- R3: A deliver request whose source priority is less than or equal to the task priority is dropped. The raised set stays unchanged and `irq_out` does not rise.
- R4: A deliver request for a source whose raised bit is already set is dropped as a miss. Its activity bit is not set again.
- R5: An accepted deliver request sets the source's raised and activity bits. It also sets `irq_out` in the next cycle when the source priority is above the highest in-service priority (0 when none is in service).
- R6: An acknowledge read selects the raised source with the highest priority; on equal priority the lowest index wins. It returns that source's 8-bit vector, moves the source into the in-service set and clears `irq_out` in the next cycle.
- R7: If the selected source's activity bit has been withdrawn through `act_clr`, or its priority is no longer above the task priority, the acknowledge read returns `spur_vec`. The source's raised bit is cleared and the source does not enter service.
- R8: On acknowledge, an edge source (`src_level` bit 0) loses its activity bit, so it can be delivered again at once. A level source (`src_level` bit 1) keeps its activity bit, and further deliveries are dropped until `act_clr` withdraws it.
- R9: A write to address 2 clears the in-service source with the highest priority (lowest index on ties). It then sets `irq_out` if the top raised source's priority is above both the task priority and the highest remaining in-service priority.
- R10: Reads of address 2 and address 3 return 0. An end-of-interrupt write with nothing in service changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Deliver request strobe |
| dlv_idx | input | IDX_W | Source index of the deliver request |
| act_clr | input | NSRC | Per-source withdrawal of the activity bit |
| src_prio | input | NSRC*4 | Packed 4-bit priority per source |
| src_vec | input | NSRC*8 | Packed 8-bit vector per source |
| src_level | input | NSRC | Sense per source: 1 level, 0 edge |
| spur_vec | input | 8 | Vector returned on a spurious acknowledge |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A wrong raised bit shows up on the very next acknowledge read. A lost bit gives `spur_vec` where a vector was due, and a stuck bit gives a vector where the spurious one was due. A corrupted in-service set stays hidden until an end-of-interrupt write. At that point `irq_out` rises or stays low one cycle later, and that level shows which in-service source was retired. So the bench builds in-service stacks whose retirement order decides the line level. An activity bit that is wrong only appears on a later deliver or acknowledge of the same source, so the edge and level cases repeat deliveries to one source.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    typedef enum logic [1:0] {
        RA_TPRI = 2'd0,
        RA_ACK  = 2'd1,
        RA_EOI  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    // Outcome of an acknowledge read
    typedef struct packed {
        logic             granted;  // source enters service
        logic             drop_act; // activity bit cleared
        logic [VEC_W-1:0] vec;      // value returned on the bus
    } ack_res_t;

    function automatic logic [VEC_W-1:0] zext_prio(input logic [PRIO_W-1:0] p);
        return {{(VEC_W-PRIO_W){1'b0}}, p};
    endfunction
endpackage

// File: rtl/irq_top_pick.sv
// Highest-priority member of a set: ascending scan, strict greater-than,
// so ties resolve to the lowest index.
module irq_top_pick #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        mask,
    input  logic [NSRC*PRIO_W-1:0] prio,
    output logic                   any,
    output logic [IDX_W-1:0]       idx,
    output logic [PRIO_W-1:0]      top
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        top = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (mask[i] && (!any || prio[i*PRIO_W +: PRIO_W] > top)) begin
                any = 1'b1;
                idx = IDX_W'(i);
                top = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl
    import irq_ack_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dlv_valid,
    input  logic [IDX_W-1:0]       dlv_idx,
    input  logic [NSRC-1:0]        act_clr,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic [NSRC*VEC_W-1:0]  src_vec,
    input  logic [NSRC-1:0]        src_level,
    input  logic [VEC_W-1:0]       spur_vec,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_addr,
    input  logic [VEC_W-1:0]       reg_wdata,
    output logic [VEC_W-1:0]       reg_rdata,
    output logic                   irq_out
);
    localparam logic [PRIO_W-1:0] TPRI_RST = '1;

    logic [NSRC-1:0]   raised_q, insv_q, active_q;
    logic [NSRC-1:0]   raised_n, insv_n, active_n;
    logic [PRIO_W-1:0] tpri_q, tpri_n;
    logic              irq_n;

    reg_addr_e addr;
    logic      ack_rd, eoi_wr, tpri_wr;
    assign addr    = reg_addr_e'(reg_addr);
    assign ack_rd  = reg_rd && addr == RA_ACK;
    assign eoi_wr  = reg_wr && addr == RA_EOI;
    assign tpri_wr = reg_wr && addr == RA_TPRI;

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata[VEC_W-1:PRIO_W];

    // Top of raised set and top of in-service set
    logic              rs_any, is_any;
    logic [IDX_W-1:0]  rs_idx, is_idx;
    logic [PRIO_W-1:0] rs_prio, is_prio, is_eff;

    irq_top_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_raised (
        .mask(raised_q), .prio(src_prio), .any(rs_any), .idx(rs_idx), .top(rs_prio)
    );
    irq_top_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_insv (
        .mask(insv_q), .prio(src_prio), .any(is_any), .idx(is_idx), .top(is_prio)
    );
    assign is_eff = is_any ? is_prio : '0;

    // Highest priority left in service once the top entry retires
    logic [NSRC-1:0]   insv_rem;
    logic [PRIO_W-1:0] rem_prio;
    always_comb begin
        insv_rem = insv_q;
        if (is_any) insv_rem[is_idx] = 1'b0;
        rem_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (insv_rem[i] && src_prio[i*PRIO_W +: PRIO_W] > rem_prio)
                rem_prio = src_prio[i*PRIO_W +: PRIO_W];
        end
    end

    // Acknowledge outcome for the current top raised source
    ack_res_t ack;
    always_comb begin
        ack = '{granted: 1'b0, drop_act: 1'b0, vec: spur_vec};
        if (rs_any) begin
            if (active_q[rs_idx] && rs_prio > tpri_q) begin
                ack.granted  = 1'b1;
                ack.vec      = src_vec[rs_idx*VEC_W +: VEC_W];
                ack.drop_act = !src_level[rs_idx];
            end else begin
                ack.drop_act = 1'b1;
            end
        end
    end

    // Deliver filter
    logic [PRIO_W-1:0] dlv_prio;
    logic              dlv_ok;
    assign dlv_prio = src_prio[dlv_idx*PRIO_W +: PRIO_W];
    assign dlv_ok   = dlv_valid && dlv_prio > tpri_q
                      && !raised_q[dlv_idx] && !active_q[dlv_idx];

    always_comb begin
        raised_n = raised_q;
        insv_n   = insv_q;
        active_n = active_q & ~act_clr;
        tpri_n   = tpri_wr ? reg_wdata[PRIO_W-1:0] : tpri_q;
        irq_n    = irq_out;
        if (ack_rd) begin
            irq_n = 1'b0;
            if (rs_any) begin
                raised_n[rs_idx] = 1'b0;
                if (ack.granted)  insv_n[rs_idx]   = 1'b1;
                if (ack.drop_act) active_n[rs_idx] = 1'b0;
            end
        end
        if (eoi_wr && is_any) begin
            insv_n[is_idx] = 1'b0;
            if (rs_any && rs_prio > tpri_q && rs_prio > rem_prio)
                irq_n = 1'b1;
        end
        if (dlv_ok) begin
            raised_n[dlv_idx] = 1'b1;
            active_n[dlv_idx] = 1'b1;
            if (dlv_prio > is_eff) irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raised_q <= '0;
            insv_q   <= '0;
            active_q <= '0;
            tpri_q   <= TPRI_RST;
            irq_out  <= 1'b0;
        end else begin
            raised_q <= raised_n;
            insv_q   <= insv_n;
            active_q <= active_n;
            tpri_q   <= tpri_n;
            irq_out  <= irq_n;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (addr)
                RA_TPRI: reg_rdata = zext_prio(tpri_q);
                RA_ACK:  reg_rdata = ack.vec;
                RA_EOI:  reg_rdata = '0;
                RA_NONE: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk
    import irq_ack_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   dlv_valid,
    input logic [IDX_W-1:0]       dlv_idx,
    input logic [NSRC*PRIO_W-1:0] src_prio,
    input logic [VEC_W-1:0]       spur_vec,
    input logic                   reg_rd,
    input logic                   reg_wr,
    input logic [1:0]             reg_addr,
    input logic [VEC_W-1:0]       reg_wdata,
    input logic [VEC_W-1:0]       reg_rdata,
    input logic                   irq_out,
    input logic [PRIO_W-1:0]      tpri_q,
    input logic [NSRC-1:0]        raised_q
);
    logic [PRIO_W-1:0] d_prio;
    logic              is_ack, is_eoi_wr;
    assign d_prio    = src_prio[dlv_idx*PRIO_W +: PRIO_W];
    assign is_ack    = reg_rd && reg_addr == 2'd1;
    assign is_eoi_wr = reg_wr && reg_addr == 2'd2;

    a_r1_empty_ack_spurious: assert property (@(posedge clk) disable iff (rst)
        is_ack && raised_q == '0 |-> reg_rdata == spur_vec);

    a_r2_tpri_low_bits: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == 2'd0 |=> tpri_q == $past(reg_wdata[PRIO_W-1:0]));

    a_r3_low_prio_quiet: assert property (@(posedge clk) disable iff (rst)
        dlv_valid && d_prio <= tpri_q && !irq_out && !is_eoi_wr |=> !irq_out);

    a_r4_miss_keeps_raised: assert property (@(posedge clk) disable iff (rst)
        dlv_valid && raised_q[dlv_idx] && !is_ack |=> raised_q == $past(raised_q));

    a_r6_ack_drops_line: assert property (@(posedge clk) disable iff (rst)
        is_ack && !dlv_valid |=> !irq_out);

    a_r10_eoi_reads_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr[1] |-> reg_rdata == '0);
endmodule

bind irq_ack_ctl irq_ack_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_irq_ack_chk (
    .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_idx(dlv_idx),
    .src_prio(src_prio), .spur_vec(spur_vec), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .tpri_q(tpri_q), .raised_q(raised_q)
);

// File: tb/irq_ack_ctl_bench.sv
module irq_ack_ctl_bench;
    localparam int NSRC  = 8;
    localparam int IDX_W = 3;
    localparam logic [7:0] SPUR = 8'hFF;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               dlv_valid = 1'b0;
    logic [IDX_W-1:0]   dlv_idx = '0;
    logic [NSRC-1:0]    act_clr = '0;
    logic [NSRC*4-1:0]  src_prio = '0;
    logic [NSRC*8-1:0]  src_vec;
    logic [NSRC-1:0]    src_level = '0;
    logic [7:0]         spur_vec = SPUR;
    logic               reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0]         reg_addr = '0;
    logic [7:0]         reg_wdata = '0;
    logic [7:0]         reg_rdata;
    logic               irq_out;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ack_ctl #(.NSRC(NSRC), .IDX_W(IDX_W)) u_irq_ack_ctl (
        .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .dlv_idx(dlv_idx),
        .act_clr(act_clr), .src_prio(src_prio), .src_vec(src_vec),
        .src_level(src_level), .spur_vec(spur_vec), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_prio(input int i, input logic [3:0] p);
        src_prio[i*4 +: 4] = p;
    endtask

    task automatic deliver(input int i);
        dlv_valid = 1'b1;
        dlv_idx   = IDX_W'(i);
        tick();
        dlv_valid = 1'b0;
    endtask

    task automatic withdraw(input int i);
        act_clr[i] = 1'b1;
        tick();
        act_clr = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_rd   = 1'b1;
        reg_addr = a;
        #2 v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq after reset", irq_out, 0);
        rd(2'd0, v); check("R1 task priority reset", v, 8'h0F);
        rd(2'd1, v); check("R1 empty ack", v, SPUR);
    endtask

    task automatic t_tpri();
        logic [7:0] v;
        wr(2'd0, 8'hA5);
        rd(2'd0, v); check("R2 low bits kept", v, 8'h05);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R2 cleared", v, 8'h00);
    endtask

    task automatic t_low_prio();
        logic [7:0] v;
        wr(2'd0, 8'h03);
        set_prio(2, 4'd3);
        deliver(2);
        check("R3 equal prio no irq", irq_out, 0);
        set_prio(2, 4'd2);
        deliver(2);
        check("R3 lower prio no irq", irq_out, 0);
        rd(2'd1, v); check("R3 nothing raised", v, SPUR);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_select();
        logic [7:0] v;
        set_prio(1, 4'd5); set_prio(3, 4'd7); set_prio(6, 4'd7);
        deliver(1);
        check("R5 irq on deliver", irq_out, 1);
        deliver(3); deliver(6);
        rd(2'd1, v); check("R6 tie lowest index", v, 8'h43);
        check("R6 irq dropped", irq_out, 0);
        rd(2'd1, v); check("R6 second of tie", v, 8'h46);
        rd(2'd1, v); check("R6 lowest prio last", v, 8'h41);
        rd(2'd1, v); check("R6 raised empty", v, SPUR);
        wr(2'd2, 8'h00); wr(2'd2, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_eoi();
        logic [7:0] v;
        set_prio(1, 4'd2); set_prio(5, 4'd6); set_prio(0, 4'd4);
        deliver(1);
        rd(2'd1, v); check("R6 vec src1", v, 8'h41);
        deliver(5);
        check("R5 above in-service raises", irq_out, 1);
        rd(2'd1, v); check("R6 vec src5", v, 8'h45);
        deliver(0);
        check("R5 below in-service no irq", irq_out, 0);
        wr(2'd2, 8'h00);
        check("R9 top retired, raise", irq_out, 1);
        rd(2'd1, v); check("R9 vec src0", v, 8'h40);
        wr(2'd2, 8'h00);
        check("R9 nothing raised", irq_out, 0);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h00);
        check("R10 empty eoi no irq", irq_out, 0);
        rd(2'd1, v); check("R10 empty eoi raised empty", v, SPUR);
    endtask

    task automatic t_spurious();
        logic [7:0] v;
        set_prio(2, 4'd3);
        deliver(2);
        check("R5 irq src2", irq_out, 1);
        withdraw(2);
        rd(2'd1, v); check("R7 withdrawn spurious", v, SPUR);
        deliver(2);
        check("R7 redeliver after spurious", irq_out, 1);
        rd(2'd1, v); check("R7 vec src2", v, 8'h42);
        wr(2'd2, 8'h00);
        deliver(2);
        wr(2'd0, 8'h05);
        rd(2'd1, v); check("R7 prio fell below tpri", v, SPUR);
        wr(2'd0, 8'h00);
        // not in service: a raised lower source is not blocked
        set_prio(7, 4'd1);
        deliver(7);
        check("R7 spurious not in service", irq_out, 1);
        rd(2'd1, v); check("R7 vec src7", v, 8'h47);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_miss();
        logic [7:0] v;
        set_prio(4, 4'd5);
        deliver(4);
        withdraw(4);
        deliver(4);
        rd(2'd1, v); check("R4 miss dropped", v, SPUR);
    endtask

    task automatic t_sense();
        logic [7:0] v;
        src_level[6] = 1'b1;
        set_prio(6, 4'd5);
        deliver(6);
        rd(2'd1, v); check("R8 level vec", v, 8'h46);
        wr(2'd2, 8'h00);
        deliver(6);
        check("R8 level still active", irq_out, 0);
        rd(2'd1, v); check("R8 level redeliver dropped", v, SPUR);
        withdraw(6);
        deliver(6);
        check("R8 level after withdraw", irq_out, 1);
        rd(2'd1, v); check("R8 level vec again", v, 8'h46);
        wr(2'd2, 8'h00);
        withdraw(6);
        deliver(4);
        rd(2'd1, v); check("R8 edge vec", v, 8'h44);
        wr(2'd2, 8'h00);
        deliver(4);
        check("R8 edge redeliver", irq_out, 1);
        rd(2'd1, v); check("R8 edge vec again", v, 8'h44);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_zero_reads();
        logic [7:0] v;
        rd(2'd2, v); check("R10 eoi read", v, 0);
        rd(2'd3, v); check("R10 unused read", v, 0);
    endtask

    initial begin
        for (int i = 0; i < NSRC; i++) src_vec[i*8 +: 8] = 8'h40 + 8'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tpri();
        t_low_prio();
        t_select();
        t_eoi();
        t_spurious();
        t_miss();
        t_sense();
        t_zero_reads();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=0x0 expected=0x1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule